// File: doc/BRIEF.md
# Bridge System Error Reporter

This block gathers the system-error conditions of a two-port bus-to-bus bridge and drives a single active-low system error line on the primary side. It watches several sources. The first is the secondary bus's own error line. It also takes abort and parity strobes from the transaction engines, each tagged with a transaction type. Finally, it counts target retries per transaction and gives up on delivery once a programmable limit is reached, which is 2^24 by default. A master enable from the command register gates every assertion of the primary line. A separate forwarding enable from the bridge control register gates only the path from the secondary error line.

Every assertion of the primary line is a one-clock low pulse, and events that arrive in the same cycle merge into one pulse. Two sticky status bits record the error activity: one for a received secondary error and one for a signaled primary error. Software clears each of them by writing 1 to it. When the retry counter expires, the block also reports a one-cycle discard event that carries the type of the transaction being dropped.

Top module: `bridge_serr_reporter`

## Requirements
- R1: While reset is held and on the first cycle after it, `priSerrN` is 1, both status bits are 0, `discardEvt` is 0 and `discardKind` is 0.
- R2: While `cmdSerrEn` is 0, no cause drives `priSerrN` low and `sigSerrSts` is not set.
- R3: A cycle in which `secSerrN` is sampled low after being high, with `fwdSerrEn` and `cmdSerrEn` both 1, drives `priSerrN` low for the following cycle. With `fwdSerrEn` 0, the secondary line never drives `priSerrN`.
- R4: Any cycle in which `secSerrN` is sampled low sets `recvSerrSts` on the next cycle, whatever the enables are.
- R5: A target abort strobe (`tgtAbortStb`) or a master abort strobe (`mstAbortStb`) pulses `priSerrN` when `abortTxn` is posted write (code 0). For delayed write (1), delayed read (2) and other (3), the strobes have no effect.
- R6: A parity strobe pulses `priSerrN` only when `parTxn` is posted write (0), `parTgtRpt` is 1 and `parInitDet` is 0.
- R7: The RETRY_LIMIT-th `retryStb` since the last restart produces a one-cycle `discardEvt` on the next cycle, with `discardKind` equal to `retryTxn`, and the count starts over. A discard of type 0, 1 or 2 also pulses `priSerrN`; a discard of type 3 does not.
- R8: `txnStart` or `txnDone` restarts the retry count and takes priority over a retry in the same cycle.
- R9: Causes that coincide in one cycle give a single one-cycle low on `priSerrN`.
- R10: Every cycle with `priSerrN` low has `sigSerrSts` set.
- R11: Status bits are sticky. A write with `stsWrEn` clears bit 0 (received) and bit 1 (signaled) where `stsWrData` has a 1. A set condition in the same cycle wins over the clear.
- R12: Holding `secSerrN` low for several cycles gives only one pulse on `priSerrN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| secSerrN | input | 1 | Secondary bus error line, active low |
| cmdSerrEn | input | 1 | Master error enable (command register) |
| fwdSerrEn | input | 1 | Secondary forwarding enable (bridge control) |
| tgtAbortStb | input | 1 | Target abort seen by a transaction engine |
| mstAbortStb | input | 1 | Master abort seen by a transaction engine |
| abortTxn | input | 2 | Transaction type of the abort (0 PW, 1 DW, 2 DR, 3 other) |
| parStb | input | 1 | Parity event strobe |
| parTxn | input | 2 | Transaction type of the parity event |
| parTgtRpt | input | 1 | Parity error reported on the target bus |
| parInitDet | input | 1 | Parity error also detected on the initiator bus |
| retryStb | input | 1 | Target retry received for the current transaction |
| retryTxn | input | 2 | Type of the transaction being retried |
| txnStart | input | 1 | New transaction queued |
| txnDone | input | 1 | Current transaction completed |
| stsWrEn | input | 1 | Status write strobe |
| stsWrData | input | 2 | Write-1-to-clear mask: bit 0 received, bit 1 signaled |
| priSerrN | output | 1 | Primary system error line, active low |
| recvSerrSts | output | 1 | Sticky received-secondary-error bit |
| sigSerrSts | output | 1 | Sticky signaled-error bit |
| discardEvt | output | 1 | One-cycle retry-limit discard event |
| discardKind | output | 2 | Type of the transaction discarded |

## Verification
The reporter is first driven with each cause on its own: a secondary edge, each abort kind under every transaction type, and the parity cases. This separates the causes that qualify from those that look alike but must be ignored. Next, the same causes are replayed with the forwarding enable and then the master enable cleared. That shows which gate blocks which path, and it shows that the received bit still records the secondary line. Retry bursts that run to the limit are compared with bursts cut short by a start or a done, which exposes off-by-one errors in the counter. Coincident causes and a write-to-clear that lands on a set condition check pulse merging and set-over-clear priority.

// File: rtl/serr_pkg.sv
package serr_pkg;
  typedef enum logic [1:0] {
    TXN_PW    = 2'd0,
    TXN_DW    = 2'd1,
    TXN_DR    = 2'd2,
    TXN_OTHER = 2'd3
  } txn_e;

  localparam int STS_RECV = 0;
  localparam int STS_SIG  = 1;
  localparam int STS_W    = 2;
  localparam int CAUSE_W  = 4;

  typedef struct packed {
    logic             fire;
    logic             cntClr;
    logic             cntInc;
    logic             discard;
    logic [STS_W-1:0] stsSet;
    logic [STS_W-1:0] stsClr;
  } ctrl_s;
endpackage

// File: rtl/serr_ctrl.sv
module serr_ctrl
  import serr_pkg::*;
(
  input  logic             secErrN,
  input  logic             secPrev,
  input  logic             cmdEn,
  input  logic             fwdEn,
  input  logic             tgtAbort,
  input  logic             mstAbort,
  input  logic [1:0]       abortTxn,
  input  logic             parStb,
  input  logic [1:0]       parTxn,
  input  logic             parTgtRpt,
  input  logic             parInitDet,
  input  logic             retryStb,
  input  logic [1:0]       retryTxn,
  input  logic             txnStart,
  input  logic             txnDone,
  input  logic             cntAtLimit,
  input  logic             stsWrEn,
  input  logic [STS_W-1:0] stsWrData,
  output ctrl_s            ctl
);
  logic [CAUSE_W-1:0] causeVec;
  logic               restart;
  logic               discardNow;

  always_comb begin
    restart    = txnStart | txnDone;
    discardNow = retryStb & ~restart & cntAtLimit;

    causeVec[0] = ~secErrN & secPrev & fwdEn;
    causeVec[1] = (tgtAbort | mstAbort) & (txn_e'(abortTxn) == TXN_PW);
    causeVec[2] = parStb & (txn_e'(parTxn) == TXN_PW) & parTgtRpt & ~parInitDet;
    causeVec[3] = discardNow & (txn_e'(retryTxn) != TXN_OTHER);

    ctl                   = '0;
    ctl.fire              = cmdEn & (|causeVec);
    ctl.cntClr            = restart | discardNow;
    ctl.cntInc            = retryStb;
    ctl.discard           = discardNow;
    ctl.stsSet[STS_RECV]  = ~secErrN;
    ctl.stsSet[STS_SIG]   = ctl.fire;
    ctl.stsClr            = stsWrEn ? stsWrData : '0;
  end
endmodule

// File: rtl/serr_datapath.sv
module serr_datapath
  import serr_pkg::*;
#(
  parameter int RETRY_LIMIT = 1 << 24
)(
  input  logic             clk,
  input  logic             rst_n,
  input  ctrl_s            ctl,
  input  logic             secErrN,
  input  logic [1:0]       retryTxn,
  output logic             secPrev,
  output logic             cntAtLimit,
  output logic             priSerrN,
  output logic [STS_W-1:0] sts,
  output logic             discardEvt,
  output logic [1:0]       discardKind
);
  localparam int CNT_W = (RETRY_LIMIT > 1) ? $clog2(RETRY_LIMIT) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RETRY_LIMIT - 1);

  logic [CNT_W-1:0] retryCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          retryCnt <= '0;
    else if (ctl.cntClr) retryCnt <= '0;
    else if (ctl.cntInc) retryCnt <= retryCnt + 1'b1;
  end

  assign cntAtLimit = (retryCnt == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      secPrev     <= 1'b1;
      priSerrN    <= 1'b1;
      discardEvt  <= 1'b0;
      discardKind <= 2'd0;
    end else begin
      secPrev    <= secErrN;
      priSerrN   <= ~ctl.fire;
      discardEvt <= ctl.discard;
      if (ctl.discard) discardKind <= retryTxn;
    end
  end

  for (genvar b = 0; b < STS_W; b++) begin : g_sts
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             sts[b] <= 1'b0;
      else if (ctl.stsSet[b]) sts[b] <= 1'b1;
      else if (ctl.stsClr[b]) sts[b] <= 1'b0;
    end
  end
endmodule

// File: rtl/bridge_serr_reporter.sv
module bridge_serr_reporter
  import serr_pkg::*;
#(
  parameter int RETRY_LIMIT = 1 << 24
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       secSerrN,
  input  logic       cmdSerrEn,
  input  logic       fwdSerrEn,
  input  logic       tgtAbortStb,
  input  logic       mstAbortStb,
  input  logic [1:0] abortTxn,
  input  logic       parStb,
  input  logic [1:0] parTxn,
  input  logic       parTgtRpt,
  input  logic       parInitDet,
  input  logic       retryStb,
  input  logic [1:0] retryTxn,
  input  logic       txnStart,
  input  logic       txnDone,
  input  logic       stsWrEn,
  input  logic [1:0] stsWrData,
  output logic       priSerrN,
  output logic       recvSerrSts,
  output logic       sigSerrSts,
  output logic       discardEvt,
  output logic [1:0] discardKind
);
  ctrl_s            ctl;
  logic             secPrev;
  logic             cntAtLimit;
  logic [STS_W-1:0] sts;

  serr_ctrl u_ctrl (
    .secErrN    (secSerrN),
    .secPrev    (secPrev),
    .cmdEn      (cmdSerrEn),
    .fwdEn      (fwdSerrEn),
    .tgtAbort   (tgtAbortStb),
    .mstAbort   (mstAbortStb),
    .abortTxn   (abortTxn),
    .parStb     (parStb),
    .parTxn     (parTxn),
    .parTgtRpt  (parTgtRpt),
    .parInitDet (parInitDet),
    .retryStb   (retryStb),
    .retryTxn   (retryTxn),
    .txnStart   (txnStart),
    .txnDone    (txnDone),
    .cntAtLimit (cntAtLimit),
    .stsWrEn    (stsWrEn),
    .stsWrData  (stsWrData),
    .ctl        (ctl)
  );

  serr_datapath #(.RETRY_LIMIT(RETRY_LIMIT)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl         (ctl),
    .secErrN     (secSerrN),
    .retryTxn    (retryTxn),
    .secPrev     (secPrev),
    .cntAtLimit  (cntAtLimit),
    .priSerrN    (priSerrN),
    .sts         (sts),
    .discardEvt  (discardEvt),
    .discardKind (discardKind)
  );

  assign recvSerrSts = sts[STS_RECV];
  assign sigSerrSts  = sts[STS_SIG];
endmodule

// File: rtl/serr_checker.sv
module serr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       secSerrN,
  input logic       cmdSerrEn,
  input logic       stsWrEn,
  input logic [1:0] stsWrData,
  input logic       priSerrN,
  input logic       recvSerrSts,
  input logic       sigSerrSts,
  input logic       discardEvt
);
  AST_GATED_BY_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cmdSerrEn) |-> priSerrN);                                   // R2
  AST_SIG_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !priSerrN |-> sigSerrSts);                                         // R10
  AST_RECV_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !secSerrN |=> recvSerrSts);                                        // R4
  AST_RECV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    recvSerrSts && !(stsWrEn && stsWrData[0]) |=> recvSerrSts);        // R11
  AST_SIG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    sigSerrSts && !(stsWrEn && stsWrData[1]) |=> sigSerrSts);          // R11
  AST_DISCARD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    discardEvt |=> !discardEvt);                                       // R7
endmodule

bind bridge_serr_reporter serr_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .secSerrN    (secSerrN),
  .cmdSerrEn   (cmdSerrEn),
  .stsWrEn     (stsWrEn),
  .stsWrData   (stsWrData),
  .priSerrN    (priSerrN),
  .recvSerrSts (recvSerrSts),
  .sigSerrSts  (sigSerrSts),
  .discardEvt  (discardEvt)
);

// File: tb/sim_bridge_serr_reporter.sv
`timescale 1ns/1ps
module sim_bridge_serr_reporter;
  localparam int LIM = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic secSerrN = 1'b1, cmdSerrEn = 1'b0, fwdSerrEn = 1'b0;
  logic tgtAbortStb = 1'b0, mstAbortStb = 1'b0;
  logic [1:0] abortTxn = 2'd0, parTxn = 2'd0, retryTxn = 2'd0, stsWrData = 2'd0;
  logic parStb = 1'b0, parTgtRpt = 1'b0, parInitDet = 1'b0;
  logic retryStb = 1'b0, txnStart = 1'b0, txnDone = 1'b0, stsWrEn = 1'b0;
  logic priSerrN, recvSerrSts, sigSerrSts, discardEvt;
  logic [1:0] discardKind;

  always #4 clk = ~clk;

  bridge_serr_reporter #(.RETRY_LIMIT(LIM)) u0 (.*);

  int errs = 0, checks = 0, lowCnt = 0, discCnt = 0;
  string curReq = "R1";

  // behavioural reference
  bit mP = 1, mRecv = 0, mSig = 0, mDisc = 0, mPrevSec = 1;
  bit [1:0] mKind = 0;
  int mCnt = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mP = 1; mRecv = 0; mSig = 0; mDisc = 0; mKind = 0; mPrevSec = 1; mCnt = 0;
    end else begin
      bit fire, disc;
      fire = 0; disc = 0;
      if (!secSerrN && mPrevSec && fwdSerrEn) fire = 1;
      if ((tgtAbortStb || mstAbortStb) && abortTxn == 2'd0) fire = 1;
      if (parStb && parTxn == 2'd0 && parTgtRpt && !parInitDet) fire = 1;
      if (txnStart || txnDone) mCnt = 0;
      else if (retryStb) begin
        if (mCnt == LIM - 1) begin disc = 1; mCnt = 0; end
        else mCnt++;
      end
      if (disc && retryTxn != 2'd3) fire = 1;
      if (!cmdSerrEn) fire = 0;
      mP = !fire;
      if (fire) mSig = 1; else if (stsWrEn && stsWrData[1]) mSig = 0;
      if (!secSerrN) mRecv = 1; else if (stsWrEn && stsWrData[0]) mRecv = 0;
      mDisc = disc;
      if (disc) mKind = retryTxn;
      mPrevSec = secSerrN;
    end
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", curReq, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    chk("priSerrN", priSerrN, mP);
    chk("recvSerrSts", recvSerrSts, mRecv);
    chk("sigSerrSts", sigSerrSts, mSig);
    chk("discardEvt", discardEvt, mDisc);
    chk("discardKind", discardKind, mKind);
    if (priSerrN === 1'b0) lowCnt++;
    if (discardEvt === 1'b1) discCnt++;
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clearAll();
    stsWrEn = 1; stsWrData = 2'b11; tick(1);
    stsWrEn = 0; stsWrData = 0; tick(1);
  endtask

  task automatic abortPulse(bit mst, bit [1:0] t);
    abortTxn = t; tgtAbortStb = !mst; mstAbortStb = mst; tick(1);
    tgtAbortStb = 0; mstAbortStb = 0; tick(2);
  endtask

  task automatic parPulse(bit [1:0] t, bit tgt, bit ini);
    parTxn = t; parTgtRpt = tgt; parInitDet = ini; parStb = 1; tick(1);
    parStb = 0; tick(2);
  endtask

  task automatic retries(int n, bit [1:0] t);
    retryTxn = t;
    for (int i = 0; i < n; i++) begin retryStb = 1; tick(1); end
    retryStb = 0; tick(2);
  endtask

  task automatic secLow(int n);
    secSerrN = 0; tick(n); secSerrN = 1; tick(2);
  endtask

  initial begin
    int base;
    curReq = "R1";
    tick(3);
    chk("reset priSerrN", priSerrN, 1);
    chk("reset discardKind", discardKind, 0);
    rst_n = 1; tick(2);

    curReq = "R3"; cmdSerrEn = 1; fwdSerrEn = 1;
    base = lowCnt; secLow(1);
    chk("R3 secondary pulse count", lowCnt - base, 1);
    curReq = "R12"; base = lowCnt; secLow(4);
    chk("R12 held low single pulse", lowCnt - base, 1);
    curReq = "R10"; chk("R10 signaled set", sigSerrSts, 1);

    curReq = "R11"; clearAll();
    chk("R11 cleared recv", recvSerrSts, 0);
    secSerrN = 0; fwdSerrEn = 0; stsWrEn = 1; stsWrData = 2'b01; tick(1);
    stsWrEn = 0; tick(1); secSerrN = 1; tick(1);
    chk("R11 set wins over clear", recvSerrSts, 1);
    curReq = "R4"; chk("R4 recv with forwarding off", recvSerrSts, 1);
    curReq = "R3"; chk("R3 no pulse with forwarding off", sigSerrSts, 0);
    fwdSerrEn = 1; clearAll();

    curReq = "R5"; base = lowCnt;
    for (int t = 0; t < 4; t++) begin
      abortPulse(0, 2'(t)); abortPulse(1, 2'(t));
    end
    chk("R5 abort pulses only for posted write", lowCnt - base, 2);

    curReq = "R6"; base = lowCnt;
    parPulse(0, 1, 0); parPulse(0, 1, 1); parPulse(0, 0, 0);
    parPulse(1, 1, 0); parPulse(2, 1, 0);
    chk("R6 parity qualifying pulses", lowCnt - base, 1);

    curReq = "R7"; base = lowCnt; discCnt = 0;
    retries(LIM, 2'd1);
    chk("R7 discard kind", discardKind, 1);
    retries(LIM, 2'd2); retries(LIM, 2'd0); retries(LIM, 2'd3);
    chk("R7 discard count", discCnt, 4);
    chk("R7 error pulses", lowCnt - base, 3);
    retries(2 * LIM, 2'd1);
    chk("R7 back-to-back discards", discCnt, 6);

    curReq = "R8"; discCnt = 0;
    retries(LIM - 1, 2'd0);
    txnStart = 1; retryStb = 1; tick(1); txnStart = 0; retryStb = 0; tick(1);
    retries(LIM - 1, 2'd0);
    txnDone = 1; tick(1); txnDone = 0;
    retries(LIM - 1, 2'd0);
    chk("R8 restart prevents discard", discCnt, 0);
    retries(1, 2'd0);
    chk("R8 discard after full run", discCnt, 1);

    curReq = "R9"; base = lowCnt;
    secSerrN = 0; tgtAbortStb = 1; abortTxn = 0;
    parStb = 1; parTxn = 0; parTgtRpt = 1; parInitDet = 0; tick(1);
    secSerrN = 1; tgtAbortStb = 0; parStb = 0; tick(3);
    chk("R9 merged pulse", lowCnt - base, 1);

    curReq = "R2"; clearAll(); cmdSerrEn = 0; base = lowCnt;
    secLow(2); abortPulse(0, 0); abortPulse(1, 0); parPulse(0, 1, 0);
    retries(LIM, 2'd0);
    chk("R2 no pulses with enable off", lowCnt - base, 0);
    chk("R2 signaled stays clear", sigSerrSts, 0);
    chk("R2 received still set", recvSerrSts, 1);

    tick(2);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule